// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

The sequencer sits between a simple request port and a byte-level SPI master engine that drives a serial NOR flash with 24-bit addressing. It accepts one request at a time: identification read, sector erase, write of any length at any address, or read. For each request it produces the correct series of transaction descriptors. A descriptor carries the opcode, an address with an address-present flag, and a data byte count. The engine acknowledges each descriptor, asks for or delivers one byte per data beat, and signals when the transaction has finished.

Erase and write requests are wrapped without further action from the requester. Every erase and every page program is preceded by a write-enable command. After each one, the status register is read again and again until the flash reports idle. A write is cut into program commands that never cross a 256-byte page. Write data is pulled from a byte source one byte per program data beat. Read data is passed out one byte per beat. A poll limit guards against a flash that never leaves the busy state.

Top module: `flash_seq`

## Requirements
- R1: Request codes on `req_op_i` are 0 identification, 1 sector erase, 2 write, 3 read. Each issued descriptor uses opcode 0x9F for identification, 0x06 for write enable, 0x05 for status read, 0x20 for sector erase, 0x02 for page program and 0x03 for read. Only erase, program and read carry an address (`cmd_addr_en_o`=1). Their data counts are 3 for identification, 0 for write enable and erase, 1 for status, and the requested length for read.
- R2: A write-enable descriptor immediately precedes every sector erase and every page program.
- R3: After each erase or program, status-read descriptors repeat until a received status byte has bit 0 clear. No other command is issued in between.
- R4: A write at page offset A of length N programs min(N, 256−A) bytes first, then whole 256-byte pages, then any remainder. No program descriptor crosses a page boundary, and none has a length of zero.
- R5: The sector erase address has bits 11:0 cleared. Bits above that are taken from the request.
- R6: During identification and status reads, every outgoing byte is 0xFF. After identification, `id_o` holds the three received bytes, the first received byte in bits 23:16.
- R7: During a page program, each data beat pops one byte from `wr_data_i` (`wr_pop_o`=1) and sends it unchanged, in order. During a read, each received byte appears on `rd_data_o` with `rd_valid_o`=1 in the same cycle.
- R8: A write of length zero issues no descriptor. `done_o` pulses in the cycle after acceptance.
- R9: `busy_o` is high from the cycle after acceptance until the request completes. `done_o` is a one-cycle pulse, is never high together with `busy_o`, and requests are accepted only while `busy_o` is low.
- R10: If MAX_POLLS status reads in a row all return bit 0 set, polling stops, `err_o` rises and `done_o` pulses. `err_o` clears when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken while idle |
| req_op_i | input | 2 | Request code |
| req_addr_i | input | ADDR_W | Flash byte address |
| req_len_i | input | LEN_W | Byte count for write or read |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Poll limit reached on the last request |
| id_o | output | 24 | Identification result |
| cmd_valid_o | output | 1 | Descriptor offered to the engine |
| cmd_ready_i | input | 1 | Engine takes the descriptor |
| cmd_op_o | output | 8 | Descriptor opcode |
| cmd_addr_o | output | ADDR_W | Descriptor address |
| cmd_addr_en_o | output | 1 | Address phase present |
| cmd_len_o | output | LEN_W | Data byte count |
| cmd_done_i | input | 1 | Engine finished the transaction |
| tx_req_i | input | 1 | Engine data beat, wants an outgoing byte |
| tx_byte_o | output | 8 | Outgoing byte |
| rx_valid_i | input | 1 | Received byte present |
| rx_byte_i | input | 8 | Received byte |
| wr_data_i | input | 8 | Write data source head |
| wr_pop_o | output | 1 | Write data byte consumed |
| rd_valid_o | output | 1 | Read byte valid |
| rd_data_o | output | 8 | Read byte |

## Verification
Data-beat outputs (`tx_byte_o`, `wr_pop_o`, `rd_valid_o`) are combinational from the beat inputs, so the bench samples them 1 ns after driving the beat, in the same cycle. Each new descriptor shows up on `cmd_valid_o` one edge after the engine's done pulse. `done_o` rises one edge after the `cmd_done_i` that ends the request, and one edge after acceptance for a zero-length write. The bench therefore samples on falling edges and waits for `done_o` before reading `id_o`, `err_o` and its own transaction log. Expected command lists and page splits are recomputed from the request address and length, and compared with every descriptor the model engine received.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {REQ_ID = 2'd0, REQ_ERASE = 2'd1, REQ_WRITE = 2'd2, REQ_READ = 2'd3} req_op_e;
  typedef enum logic [2:0] {K_ID, K_WEN, K_ERASE, K_PROG, K_POLL, K_READ} cmd_kind_e;
  typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_WAIT} phase_e;
  localparam logic [7:0] OPC_ID   = 8'h9F;
  localparam logic [7:0] OPC_WEN  = 8'h06;
  localparam logic [7:0] OPC_STAT = 8'h05;
  localparam logic [7:0] OPC_SE   = 8'h20;
  localparam logic [7:0] OPC_PP   = 8'h02;
  localparam logic [7:0] OPC_RD   = 8'h03;
  localparam logic [7:0] FILL     = 8'hFF;
endpackage

// File: rtl/flash_chunk.sv
module flash_chunk #(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  remain_i,
  output logic [LEN_W-1:0]  chunk_o
);
  localparam int PAGE_BITS = $clog2(PAGE_BYTES);
  logic [LEN_W-1:0] room;
  assign room    = LEN_W'(PAGE_BYTES) - LEN_W'(addr_i[PAGE_BITS-1:0]);
  assign chunk_o = (remain_i < room) ? remain_i : room;
endmodule

// File: rtl/flash_desc.sv
module flash_desc
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int LEN_W        = 16,
  parameter int SECTOR_BYTES = 4096
) (
  input  cmd_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  chunk_i,
  input  logic [LEN_W-1:0]  rd_len_i,
  output logic [7:0]        op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_en_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam int SEC_BITS = $clog2(SECTOR_BYTES);
  always_comb begin
    op_o      = OPC_STAT;
    addr_o    = addr_i;
    addr_en_o = 1'b0;
    len_o     = '0;
    unique case (kind_i)
      K_ID:    begin op_o = OPC_ID; len_o = LEN_W'(3); end
      K_WEN:   op_o = OPC_WEN;
      K_ERASE: begin
        op_o = OPC_SE; addr_en_o = 1'b1;
        addr_o = {addr_i[ADDR_W-1:SEC_BITS], {SEC_BITS{1'b0}}};
      end
      K_PROG:  begin op_o = OPC_PP; addr_en_o = 1'b1; len_o = chunk_i; end
      K_POLL:  begin op_o = OPC_STAT; len_o = LEN_W'(1); end
      K_READ:  begin op_o = OPC_RD; addr_en_o = 1'b1; len_o = rd_len_i; end
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_rx_cap.sv
module flash_rx_cap (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        id_en_i,
  input  logic        stat_en_i,
  input  logic [7:0]  byte_i,
  output logic [23:0] id_o,
  output logic [7:0]  stat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_o   <= '0;
      stat_o <= '0;
    end else begin
      if (id_en_i)   id_o   <= {id_o[15:0], byte_i};
      if (stat_en_i) stat_o <= byte_i;
    end
  end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int LEN_W        = 16,
  parameter int PAGE_BYTES   = 256,
  parameter int SECTOR_BYTES = 4096,
  parameter int MAX_POLLS    = 65536
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [23:0]       id_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [7:0]        cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              cmd_addr_en_o,
  output logic [LEN_W-1:0]  cmd_len_o,
  input  logic              cmd_done_i,
  input  logic              tx_req_i,
  output logic [7:0]        tx_byte_o,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  input  logic [7:0]        wr_data_i,
  output logic              wr_pop_o,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o
);
  localparam int PC_W = $clog2(MAX_POLLS + 1);

  phase_e            phase;
  cmd_kind_e         kind;
  req_op_e           req_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  remain_q, rd_len_q, chunk;
  logic [PC_W-1:0]   polls_q;
  logic [7:0]        stat;
  logic              in_xfer, accept;

  assign accept  = req_valid_i && (phase == PH_IDLE);
  assign in_xfer = (phase == PH_WAIT);
  assign busy_o  = (phase != PH_IDLE);

  flash_chunk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_chunk (
    .addr_i(addr_q), .remain_i(remain_q), .chunk_o(chunk)
  );

  flash_desc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SECTOR_BYTES(SECTOR_BYTES)) u_desc (
    .kind_i(kind), .addr_i(addr_q), .chunk_i(chunk), .rd_len_i(rd_len_q),
    .op_o(cmd_op_o), .addr_o(cmd_addr_o), .addr_en_o(cmd_addr_en_o), .len_o(cmd_len_o)
  );

  flash_rx_cap u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .id_en_i(rx_valid_i && in_xfer && kind == K_ID),
    .stat_en_i(rx_valid_i && in_xfer && kind == K_POLL),
    .byte_i(rx_byte_i), .id_o(id_o), .stat_o(stat)
  );

  assign cmd_valid_o = (phase == PH_ISSUE);
  assign tx_byte_o   = (kind == K_PROG) ? wr_data_i : FILL;
  assign wr_pop_o    = tx_req_i && in_xfer && kind == K_PROG;
  assign rd_valid_o  = rx_valid_i && in_xfer && kind == K_READ;
  assign rd_data_o   = rx_byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase    <= PH_IDLE;
      kind     <= K_ID;
      req_q    <= REQ_ID;
      addr_q   <= '0;
      remain_q <= '0;
      rd_len_q <= '0;
      polls_q  <= '0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (phase)
        PH_IDLE: if (accept) begin
          req_q    <= req_op_e'(req_op_i);
          addr_q   <= req_addr_i;
          remain_q <= req_len_i;
          rd_len_q <= req_len_i;
          err_o    <= 1'b0;
          phase    <= PH_ISSUE;
          unique case (req_op_e'(req_op_i))
            REQ_ID:    kind <= K_ID;
            REQ_ERASE: kind <= K_WEN;
            REQ_READ:  kind <= K_READ;
            REQ_WRITE: begin
              kind <= K_WEN;
              if (req_len_i == '0) begin
                phase  <= PH_IDLE;
                done_o <= 1'b1;
              end
            end
            default: ;
          endcase
        end
        PH_ISSUE: if (cmd_ready_i) phase <= PH_WAIT;
        PH_WAIT: if (cmd_done_i) begin
          phase <= PH_ISSUE;
          unique case (kind)
            K_WEN:   kind <= (req_q == REQ_ERASE) ? K_ERASE : K_PROG;
            K_ERASE: begin kind <= K_POLL; polls_q <= '0; end
            K_PROG: begin
              addr_q   <= addr_q + ADDR_W'(chunk);
              remain_q <= remain_q - chunk;
              kind     <= K_POLL;
              polls_q  <= '0;
            end
            K_POLL: begin
              if (!stat[0]) begin
                if (req_q == REQ_WRITE && remain_q != '0) kind <= K_WEN;
                else begin phase <= PH_IDLE; done_o <= 1'b1; end
              end else if (polls_q == PC_W'(MAX_POLLS - 1)) begin
                phase  <= PH_IDLE;
                done_o <= 1'b1;
                err_o  <= 1'b1;
              end else polls_q <= polls_q + 1'b1;
            end
            default: begin phase <= PH_IDLE; done_o <= 1'b1; end
          endcase
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [7:0]        cmd_op_o,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic [LEN_W-1:0]  cmd_len_o,
  input logic              wr_pop_o
);
  // R4
  page_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_op_o == 8'h02 |->
      cmd_len_o != '0 && ((LEN_W+1)'(cmd_addr_o[7:0]) + (LEN_W+1)'(cmd_len_o)) <= (LEN_W+1)'(256));
  // R5
  sector_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_op_o == 8'h20 |-> cmd_addr_o[11:0] == 12'h000);
  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R1
  desc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_addr_o));
  // R7
  pop_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pop_o |-> busy_o && !cmd_valid_o);
  // R9
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !busy_o && !done_o |=> busy_o || done_o);
endmodule

bind flash_seq flash_seq_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/sim_flash_seq.sv
`timescale 1ns/1ps
module sim_flash_seq;
  localparam int AW = 24, LW = 16, MP = 6;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic req_valid = 0; logic [1:0] req_op = 0; logic [AW-1:0] req_addr = 0; logic [LW-1:0] req_len = 0;
  logic busy, done, err; logic [23:0] id;
  logic cmd_valid, cmd_ready = 0, cmd_addr_en, cmd_done = 0;
  logic [7:0] cmd_op; logic [AW-1:0] cmd_addr; logic [LW-1:0] cmd_len;
  logic tx_req = 0, rx_valid = 0; logic [7:0] tx_byte, rx_byte = 0;
  logic [7:0] wr_data; logic wr_pop, rd_valid; logic [7:0] rd_data;

  flash_seq #(.MAX_POLLS(MP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_len_i(req_len), .busy_o(busy), .done_o(done), .err_o(err),
    .id_o(id), .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_op_o(cmd_op),
    .cmd_addr_o(cmd_addr), .cmd_addr_en_o(cmd_addr_en), .cmd_len_o(cmd_len),
    .cmd_done_i(cmd_done), .tx_req_i(tx_req), .tx_byte_o(tx_byte), .rx_valid_i(rx_valid),
    .rx_byte_i(rx_byte), .wr_data_i(wr_data), .wr_pop_o(wr_pop), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data));

  int checks = 0, errors = 0;
  logic [7:0] mem [0:8191];
  logic [7:0] wbuf [0:1023];
  logic [7:0] rbuf [0:1023];
  int wptr = 0, rcnt = 0, busy_cfg = 0, busy_left = 0;
  logic [7:0] log_op [0:63]; logic [AW-1:0] log_addr [0:63]; int log_len [0:63];
  logic log_aen [0:63]; logic log_ff [0:63]; int pops [0:63];
  int n_log = 0;
  assign wr_data = wbuf[wptr];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // model engine + flash
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid && !cmd_ready) begin
        automatic int k = n_log;
        automatic logic [7:0] op = cmd_op;
        automatic logic [AW-1:0] a = cmd_addr;
        automatic int n = int'(cmd_len);
        automatic logic [7:0] pb [0:255];
        log_op[k] = op; log_addr[k] = a; log_len[k] = n; log_aen[k] = cmd_addr_en;
        log_ff[k] = 1; pops[k] = 0;
        n_log = (k < 63) ? k + 1 : k;
        cmd_ready = 1;
        @(negedge clk); cmd_ready = 0;
        for (int i = 0; i < n; i++) begin
          tx_req = 1; rx_valid = 1;
          case (op)
            8'h9F: rx_byte = (i == 0) ? 8'hEF : (i == 1) ? 8'h40 : 8'h17;
            8'h05: rx_byte = (busy_left > 0) ? 8'h03 : 8'h02;
            8'h03: rx_byte = mem[(int'(a) + i) % 8192];
            default: rx_byte = 8'h00;
          endcase
          #1;
          if (tx_byte != 8'hFF) log_ff[k] = 0;
          if (op == 8'h02) begin
            if (i < 256) pb[i] = tx_byte;
            if (wr_pop) begin pops[k]++; wptr++; end
          end
          if (rd_valid) begin
            chk(rd_data == rx_byte, "R7 rd_data", rd_data, rx_byte);
            if (rcnt < 1024) rbuf[rcnt] = rd_data;
            rcnt++;
          end
          @(negedge clk);
        end
        tx_req = 0; rx_valid = 0;
        cmd_done = 1;
        case (op)
          8'h20: begin
            for (int j = 0; j < 4096; j++) mem[(int'(a) + j) % 8192] = 8'hFF;
            busy_left = busy_cfg;
          end
          8'h02: begin
            for (int j = 0; j < n && j < 256; j++) mem[(int'(a) + j) % 8192] = pb[j];
            busy_left = busy_cfg;
          end
          8'h05: if (busy_left > 0) busy_left--;
          default: ;
        endcase
        @(negedge clk); cmd_done = 0;
      end
    end
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic run(input logic [1:0] op, input logic [AW-1:0] a, input int n);
    n_log = 0; wptr = 0; rcnt = 0;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_len = LW'(n);
    @(negedge clk); req_valid = 0;
    while (!done) @(negedge clk);
  endtask

  task automatic check_polls(inout int k, input int expect_n, input string tag);
    for (int p = 0; p < expect_n; p++) begin
      chk(log_op[k] == 8'h05 && log_len[k] == 1 && !log_aen[k] && log_ff[k], tag, log_op[k], 8'h05);
      k++;
    end
  endtask

  task automatic check_write(input logic [AW-1:0] a0, input int n, input int seed);
    automatic int a = int'(a0), r = n, k = 0, off = 0;
    for (int i = 0; i < n; i++) wbuf[i] = 8'((i * 7 + seed) & 255);
    busy_cfg = 1;
    run(2, a0, n);
    while (r > 0) begin
      automatic int c = (r < 256 - (a % 256)) ? r : 256 - (a % 256);
      chk(log_op[k] == 8'h06 && log_len[k] == 0 && !log_aen[k], "R2 wen before program", log_op[k], 8'h06);
      k++;
      chk(log_op[k] == 8'h02 && log_aen[k], "R1 program opcode", log_op[k], 8'h02);
      chk(int'(log_addr[k]) == a, "R4 chunk addr", log_addr[k], a);
      chk(log_len[k] == c, "R4 chunk len", log_len[k], c);
      chk(pops[k] == c, "R7 pops", pops[k], c);
      k++;
      check_polls(k, 2, "R3 poll after program");
      a += c; r -= c; off += c;
    end
    chk(n_log == k, "R3 no extra cmds", n_log, k);
    for (int i = 0; i < n; i++)
      if (mem[(int'(a0) + i) % 8192] != wbuf[i]) begin
        chk(0, "R7 written data", mem[(int'(a0) + i) % 8192], wbuf[i]);
        break;
      end
    chk(!err, "R10 no err", err, 0);
  endtask

  initial begin
    for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
    #1;
    chk(!busy && !done && !err && !cmd_valid, "R9 reset state", {busy, done, err, cmd_valid}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // identification
    run(0, 0, 0);
    chk(n_log == 1 && log_op[0] == 8'h9F && log_len[0] == 3 && !log_aen[0], "R1 id desc", log_op[0], 8'h9F);
    chk(log_ff[0], "R6 id filler", log_ff[0], 1);
    chk(id == 24'hEF4017, "R6 id value", id, 24'hEF4017);

    // erase sectors 0 and 1 with misaligned addresses
    for (int s = 0; s < 2; s++) begin
      automatic int k = 2;
      busy_cfg = 3;
      run(1, AW'(s * 4096 + 12'h234), 0);
      chk(log_op[0] == 8'h06, "R2 wen before erase", log_op[0], 8'h06);
      chk(log_op[1] == 8'h20 && log_aen[1] && log_len[1] == 0, "R1 erase desc", log_op[1], 8'h20);
      chk(log_addr[1] == AW'(s * 4096), "R5 erase align", log_addr[1], s * 4096);
      check_polls(k, 4, "R3 poll after erase");
      chk(n_log == 6, "R3 erase cmd count", n_log, 6);
      chk(mem[s * 4096 + 5] == 8'hFF, "R5 erased", mem[s * 4096 + 5], 8'hFF);
    end

    // write sweep over offsets and lengths
    check_write(AW'(24'h000010), 10, 1);
    check_write(AW'(24'h0000F0), 48, 2);
    check_write(AW'(24'h000100), 512, 3);
    check_write(AW'(24'h0000FF), 1, 4);
    check_write(AW'(24'h0001C0), 600, 5);
    check_write(AW'(24'h000500), 256, 6);

    // read back last region via rd port
    for (int i = 0; i < 600; i++) wbuf[i] = 8'((i * 7 + 5) & 255);
    run(3, AW'(24'h0001C0), 600);
    chk(n_log == 1 && log_op[0] == 8'h03 && log_aen[0] && log_len[0] == 600, "R1 read desc", log_len[0], 600);
    chk(rcnt == 600, "R7 read count", rcnt, 600);
    for (int i = 0; i < 600; i++)
      if (rbuf[i] != wbuf[i]) begin chk(0, "R7 read data", rbuf[i], wbuf[i]); break; end

    // zero-length write: done one cycle after accept, no command
    n_log = 0;
    @(negedge clk);
    req_valid = 1; req_op = 2; req_addr = 24'h000300; req_len = 0;
    @(negedge clk); req_valid = 0;
    chk(done && !busy, "R8 zero len done", {done, busy}, 2'b10);
    repeat (4) @(negedge clk);
    chk(n_log == 0 && !cmd_valid, "R8 no command", n_log, 0);

    // busy high during a request
    busy_cfg = 0;
    n_log = 0; wptr = 0;
    @(negedge clk);
    req_valid = 1; req_op = 1; req_addr = 24'h001000; req_len = 0;
    @(negedge clk); req_valid = 0;
    chk(busy && !done, "R9 busy after accept", busy, 1);
    while (!done) begin
      if (!busy) begin chk(0, "R9 busy dropped", busy, 1); break; end
      @(negedge clk);
    end
    @(negedge clk);
    chk(!done, "R9 done pulse", done, 0);

    // poll timeout
    busy_cfg = 100;
    run(1, 24'h000000, 0);
    chk(err, "R10 err set", err, 1);
    chk(n_log == 2 + MP, "R10 poll limit", n_log, 2 + MP);
    busy_left = 0; busy_cfg = 0;
    run(0, 0, 0);
    chk(!err, "R10 err cleared", err, 0);

    finish_run();
  end
endmodule